// File: doc/BRIEF.md
# Framebuffer Viewport Scanout Address Generator

This block holds the configuration of a framebuffer whose allocated buffer may be larger than the visible display. It stores the display size, the buffer size, the viewport origin inside the buffer, the pixel depth and the buffer base address. As the raster position advances, it produces one memory read address per visible display pixel. Only a display-sized window, positioned at the viewport origin, is read out. Moving the origin scrolls the picture or flips between buffers.

Settings arrive one field at a time on a write port. A setting that is out of range is clamped to a legal value; the request never fails. Every write runs the whole validation again, so a change to one field can adjust the fields that depend on it. Read-back returns the clamped values. The validated set stays pending until a frame-start pulse copies it into the active set. The address generator, the pitch output and the size output use only the active set.

Top module: `fbv_scan_addr`

## Requirements
- R1: After reset both the pending and the active configuration hold the power-on defaults: display 640x480, buffer 640x480, origin (0,0), depth 16 and base DEF_BASE (default 0x0010_0000). This is true whatever was written before the reset.
- R2: A written display width or height of 0 becomes 1, and a value above MAX_DIM (default 2048) becomes MAX_DIM.
- R3: The buffer width and height are clamped to at most MAX_DIM and raised to at least the matching display size.
- R4: The origin x and y are clamped so that origin plus display size never exceeds the buffer size on that axis.
- R5: A depth of 8, 16, 24 or 32 is kept. Any other depth value becomes 16.
- R6: Each write applies the value at wr_sel and then checks all fields again. wr_sel codes are: 0 display width, 1 display height, 2 buffer width, 3 buffer height, 4 origin x, 5 origin y, 6 depth, 7 base. rd_data shows the pending, clamped field picked by rd_sel, using the same codes, with its value zero-extended.
- R7: The pending configuration becomes active at the clock edge where frame_start is high. Until then, pitch, size and the generated addresses keep using the previous active set.
- R8: pitch_o equals buffer width times depth/8, and size_o equals pitch_o times buffer height, both taken from the active set.
- R9: One cycle after pix_valid is high with pix_x below the display width and pix_y below the display height, rd_addr_valid is high. In that case rd_addr = base + (pix_y+origin_y)*pitch + (pix_x+origin_x)*depth/8. In every other case rd_addr_valid is low in that cycle.
- R10: Every valid read address lies within [base, base+size).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe for one configuration field |
| wr_sel | input | 3 | Field code for the write |
| wr_data | input | 32 | Candidate value for the field |
| rd_sel | input | 3 | Field code for read-back |
| rd_data | output | 32 | Pending clamped value of the selected field |
| frame_start | input | 1 | Copies the pending set into the active set |
| pix_valid | input | 1 | Raster position is valid this cycle |
| pix_x | input | DIM_W | Display column |
| pix_y | input | DIM_W | Display row |
| rd_addr_valid | output | 1 | rd_addr holds a valid pixel address |
| rd_addr | output | ADDR_W | Byte address of the pixel in memory |
| pitch_o | output | PITCH_W | Active row pitch in bytes |
| size_o | output | SIZE_W | Active buffer size in bytes |

## Verification
Some properties are checked by assertions on every cycle:
- the pending set always keeps the buffer at least as large as the display, keeps the origin inside the buffer, and holds a legal depth;
- the active set changes only on frame_start;
- no valid address falls outside the active buffer;
- no address appears without a pixel request.

Other behaviour can only be shown by the bench's directed scenarios:
- the exact clamped value that a given out-of-range write produces;
- how a write to one field re-clamps the fields that depend on it;
- the deferral of a new configuration until the frame boundary;
- the exact address arithmetic at the corners of the viewport.

// File: rtl/fbv_pkg.sv
package fbv_pkg;

  typedef enum logic [2:0] {
    SEL_DISP_W = 3'd0,
    SEL_DISP_H = 3'd1,
    SEL_BUF_W  = 3'd2,
    SEL_BUF_H  = 3'd3,
    SEL_ORG_X  = 3'd4,
    SEL_ORG_Y  = 3'd5,
    SEL_DEPTH  = 3'd6,
    SEL_BASE   = 3'd7
  } cfg_sel_e;

  function automatic logic depth_legal(input logic [31:0] d);
    return (d == 32'd8) || (d == 32'd16) || (d == 32'd24) || (d == 32'd32);
  endfunction

endpackage

// File: rtl/fbv_cfg_clip.sv
module fbv_cfg_clip #(
  parameter int MAX_DIM = 2048,
  parameter int DIM_W   = 12,
  parameter int BPP_W   = 6,
  parameter int ADDR_W  = 32
) (
  input  logic [1:0][DIM_W-1:0] cur_disp,
  input  logic [1:0][DIM_W-1:0] cur_buf,
  input  logic [1:0][DIM_W-1:0] cur_org,
  input  logic [BPP_W-1:0]      cur_depth,
  input  logic [ADDR_W-1:0]     cur_base,
  input  logic                  wr_en,
  input  logic [2:0]            wr_sel,
  input  logic [31:0]           wr_data,
  output logic [1:0][DIM_W-1:0] nxt_disp,
  output logic [1:0][DIM_W-1:0] nxt_buf,
  output logic [1:0][DIM_W-1:0] nxt_org,
  output logic [BPP_W-1:0]      nxt_depth,
  output logic [ADDR_W-1:0]     nxt_base
);
  import fbv_pkg::*;

  localparam logic [31:0] MAX_V = 32'(MAX_DIM);

  logic [1:0][31:0] c_disp, c_buf, c_org;
  logic [31:0]      c_depth;
  logic [ADDR_W-1:0] c_base;

  // candidate set: current pending values with the written field replaced
  always_comb begin
    for (int a = 0; a < 2; a++) begin
      c_disp[a] = 32'(cur_disp[a]);
      c_buf[a]  = 32'(cur_buf[a]);
      c_org[a]  = 32'(cur_org[a]);
    end
    c_depth = 32'(cur_depth);
    c_base  = cur_base;
    if (wr_en) begin
      case (cfg_sel_e'(wr_sel))
        SEL_DISP_W: c_disp[0] = wr_data;
        SEL_DISP_H: c_disp[1] = wr_data;
        SEL_BUF_W:  c_buf[0]  = wr_data;
        SEL_BUF_H:  c_buf[1]  = wr_data;
        SEL_ORG_X:  c_org[0]  = wr_data;
        SEL_ORG_Y:  c_org[1]  = wr_data;
        SEL_DEPTH:  c_depth   = wr_data;
        default:    c_base    = ADDR_W'(wr_data);
      endcase
    end
  end

  // per-axis clamping chain: display, then buffer, then origin
  for (genvar a = 0; a < 2; a++) begin : g_axis
    logic [31:0] d_cl, b_cl, slack, o_cl;
    assign d_cl  = (c_disp[a] == 32'd0) ? 32'd1 :
                   (c_disp[a] > MAX_V)  ? MAX_V : c_disp[a];
    assign b_cl  = (c_buf[a] > MAX_V)   ? MAX_V :
                   (c_buf[a] < d_cl)    ? d_cl  : c_buf[a];
    assign slack = b_cl - d_cl;
    assign o_cl  = (c_org[a] > slack)   ? slack : c_org[a];
    assign nxt_disp[a] = DIM_W'(d_cl);
    assign nxt_buf[a]  = DIM_W'(b_cl);
    assign nxt_org[a]  = DIM_W'(o_cl);
  end

  assign nxt_depth = depth_legal(c_depth) ? BPP_W'(c_depth) : BPP_W'(16);
  assign nxt_base  = c_base;

endmodule

// File: rtl/fbv_cfg_bank.sv
module fbv_cfg_bank #(
  parameter int              MAX_DIM    = 2048,
  parameter int              DIM_W      = 12,
  parameter int              BPP_W      = 6,
  parameter int              ADDR_W     = 32,
  parameter int              PITCH_W    = 14,
  parameter int              SIZE_W     = 26,
  parameter int              DEF_DISP_W = 640,
  parameter int              DEF_DISP_H = 480,
  parameter int              DEF_DEPTH  = 16,
  parameter logic [ADDR_W-1:0] DEF_BASE = 32'h0010_0000
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_en,
  input  logic [2:0]            wr_sel,
  input  logic [31:0]           wr_data,
  input  logic [2:0]            rd_sel,
  output logic [31:0]           rd_data,
  input  logic                  frame_start,
  output logic [1:0][DIM_W-1:0] act_disp,
  output logic [1:0][DIM_W-1:0] act_org,
  output logic [2:0]            act_bytes,
  output logic [ADDR_W-1:0]     act_base,
  output logic [PITCH_W-1:0]    pitch_q,
  output logic [SIZE_W-1:0]     size_q
);
  import fbv_pkg::*;

  localparam logic [1:0][DIM_W-1:0] RST_DISP =
    {DIM_W'(DEF_DISP_H), DIM_W'(DEF_DISP_W)};
  localparam logic [PITCH_W-1:0] RST_PITCH =
    PITCH_W'(DEF_DISP_W * (DEF_DEPTH / 8));
  localparam logic [SIZE_W-1:0] RST_SIZE =
    SIZE_W'(DEF_DISP_W * (DEF_DEPTH / 8) * DEF_DISP_H);

  logic [1:0][DIM_W-1:0] pd_disp, pd_buf, pd_org;
  logic [BPP_W-1:0]      pd_depth;
  logic [ADDR_W-1:0]     pd_base;
  logic [1:0][DIM_W-1:0] nx_disp, nx_buf, nx_org;
  logic [BPP_W-1:0]      nx_depth;
  logic [ADDR_W-1:0]     nx_base;
  logic [PITCH_W-1:0]    pd_pitch;
  logic [SIZE_W-1:0]     pd_size;

  fbv_cfg_clip #(
    .MAX_DIM(MAX_DIM), .DIM_W(DIM_W), .BPP_W(BPP_W), .ADDR_W(ADDR_W)
  ) clip_i (
    .cur_disp(pd_disp), .cur_buf(pd_buf), .cur_org(pd_org),
    .cur_depth(pd_depth), .cur_base(pd_base),
    .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .nxt_disp(nx_disp), .nxt_buf(nx_buf), .nxt_org(nx_org),
    .nxt_depth(nx_depth), .nxt_base(nx_base)
  );

  // pending set: written only on wr_en
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pd_disp  <= RST_DISP;
      pd_buf   <= RST_DISP;
      pd_org   <= '0;
      pd_depth <= BPP_W'(DEF_DEPTH);
      pd_base  <= DEF_BASE;
    end else if (wr_en) begin
      pd_disp  <= nx_disp;
      pd_buf   <= nx_buf;
      pd_org   <= nx_org;
      pd_depth <= nx_depth;
      pd_base  <= nx_base;
    end
  end

  always_comb begin
    pd_pitch = PITCH_W'(pd_buf[0]) * PITCH_W'(pd_depth >> 3);
    pd_size  = SIZE_W'(pd_pitch) * SIZE_W'(pd_buf[1]);
  end

  // active set: copied only on frame_start
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_disp  <= RST_DISP;
      act_org   <= '0;
      act_bytes <= 3'(DEF_DEPTH / 8);
      act_base  <= DEF_BASE;
      pitch_q   <= RST_PITCH;
      size_q    <= RST_SIZE;
    end else if (frame_start) begin
      act_disp  <= pd_disp;
      act_org   <= pd_org;
      act_bytes <= 3'(pd_depth >> 3);
      act_base  <= pd_base;
      pitch_q   <= pd_pitch;
      size_q    <= pd_size;
    end
  end

  always_comb begin
    case (cfg_sel_e'(rd_sel))
      SEL_DISP_W: rd_data = 32'(pd_disp[0]);
      SEL_DISP_H: rd_data = 32'(pd_disp[1]);
      SEL_BUF_W:  rd_data = 32'(pd_buf[0]);
      SEL_BUF_H:  rd_data = 32'(pd_buf[1]);
      SEL_ORG_X:  rd_data = 32'(pd_org[0]);
      SEL_ORG_Y:  rd_data = 32'(pd_org[1]);
      SEL_DEPTH:  rd_data = 32'(pd_depth);
      default:    rd_data = 32'(pd_base);
    endcase
  end

  // R2
  disp_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pd_disp[0] != '0) && (pd_disp[1] != '0) &&
    (32'(pd_disp[0]) <= 32'(MAX_DIM)) && (32'(pd_disp[1]) <= 32'(MAX_DIM)));
  // R3
  buf_covers_disp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pd_buf[0] >= pd_disp[0]) && (pd_buf[1] >= pd_disp[1]));
  // R4
  org_fits_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (32'(pd_org[0]) + 32'(pd_disp[0]) <= 32'(pd_buf[0])) &&
    (32'(pd_org[1]) + 32'(pd_disp[1]) <= 32'(pd_buf[1])));
  // R5
  depth_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    depth_legal(32'(pd_depth)));
  // R7
  active_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_start |=> ($stable(act_disp) && $stable(act_org) &&
                      $stable(act_base) && $stable(pitch_q) && $stable(size_q)));

endmodule

// File: rtl/fbv_addr_gen.sv
module fbv_addr_gen #(
  parameter int DIM_W   = 12,
  parameter int ADDR_W  = 32,
  parameter int PITCH_W = 14,
  parameter int SIZE_W  = 26
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [1:0][DIM_W-1:0] act_disp,
  input  logic [1:0][DIM_W-1:0] act_org,
  input  logic [2:0]            act_bytes,
  input  logic [ADDR_W-1:0]     act_base,
  input  logic [PITCH_W-1:0]    pitch,
  input  logic [SIZE_W-1:0]     size,
  input  logic                  pix_valid,
  input  logic [DIM_W-1:0]      pix_x,
  input  logic [DIM_W-1:0]      pix_y,
  output logic                  addr_valid,
  output logic [ADDR_W-1:0]     addr
);

  logic              visible;
  logic [ADDR_W-1:0] row, col, addr_d;

  always_comb begin
    visible = pix_valid && (pix_x < act_disp[0]) && (pix_y < act_disp[1]);
    row     = ADDR_W'(pix_y) + ADDR_W'(act_org[1]);
    col     = ADDR_W'(pix_x) + ADDR_W'(act_org[0]);
    addr_d  = act_base + row * ADDR_W'(pitch) + col * ADDR_W'(act_bytes);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) addr_valid <= 1'b0;
    else        addr_valid <= visible;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       addr <= '0;
    else if (visible) addr <= addr_d;
  end

  // R9
  no_request_no_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !pix_valid |=> !addr_valid);
  // R10
  addr_in_buffer_chk: assert property (@(posedge clk) disable iff (!rst_n)
    addr_valid |-> ((addr - $past(act_base)) < ADDR_W'($past(size))));

endmodule

// File: rtl/fbv_scan_addr.sv
module fbv_scan_addr #(
  parameter int              MAX_DIM    = 2048,
  parameter int              DIM_W      = $clog2(MAX_DIM + 1),
  parameter int              ADDR_W     = 32,
  parameter int              DEF_DISP_W = 640,
  parameter int              DEF_DISP_H = 480,
  parameter int              DEF_DEPTH  = 16,
  parameter logic [ADDR_W-1:0] DEF_BASE = 32'h0010_0000,
  parameter int              PITCH_W    = DIM_W + 2,
  parameter int              SIZE_W     = PITCH_W + DIM_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [2:0]         wr_sel,
  input  logic [31:0]        wr_data,
  input  logic [2:0]         rd_sel,
  output logic [31:0]        rd_data,
  input  logic               frame_start,
  input  logic               pix_valid,
  input  logic [DIM_W-1:0]   pix_x,
  input  logic [DIM_W-1:0]   pix_y,
  output logic               rd_addr_valid,
  output logic [ADDR_W-1:0]  rd_addr,
  output logic [PITCH_W-1:0] pitch_o,
  output logic [SIZE_W-1:0]  size_o
);

  localparam int BPP_W = 6;

  logic [1:0][DIM_W-1:0] act_disp, act_org;
  logic [2:0]            act_bytes;
  logic [ADDR_W-1:0]     act_base;

  fbv_cfg_bank #(
    .MAX_DIM(MAX_DIM), .DIM_W(DIM_W), .BPP_W(BPP_W), .ADDR_W(ADDR_W),
    .PITCH_W(PITCH_W), .SIZE_W(SIZE_W), .DEF_DISP_W(DEF_DISP_W),
    .DEF_DISP_H(DEF_DISP_H), .DEF_DEPTH(DEF_DEPTH), .DEF_BASE(DEF_BASE)
  ) bank_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
    .wr_data(wr_data), .rd_sel(rd_sel), .rd_data(rd_data),
    .frame_start(frame_start), .act_disp(act_disp), .act_org(act_org),
    .act_bytes(act_bytes), .act_base(act_base),
    .pitch_q(pitch_o), .size_q(size_o)
  );

  fbv_addr_gen #(
    .DIM_W(DIM_W), .ADDR_W(ADDR_W), .PITCH_W(PITCH_W), .SIZE_W(SIZE_W)
  ) agen_i (
    .clk(clk), .rst_n(rst_n), .act_disp(act_disp), .act_org(act_org),
    .act_bytes(act_bytes), .act_base(act_base), .pitch(pitch_o),
    .size(size_o), .pix_valid(pix_valid), .pix_x(pix_x), .pix_y(pix_y),
    .addr_valid(rd_addr_valid), .addr(rd_addr)
  );

endmodule

// File: tb/fbv_scan_addr_tb_top.sv
module fbv_scan_addr_tb_top;

  localparam int DIM_W   = 12;
  localparam int PITCH_W = 14;
  localparam int SIZE_W  = 26;
  localparam logic [31:0] DBASE = 32'h0010_0000;

  logic               clk = 1'b0;
  logic               rst_n = 1'b0;
  logic               wr_en = 1'b0;
  logic [2:0]         wr_sel = '0;
  logic [31:0]        wr_data = '0;
  logic [2:0]         rd_sel = '0;
  logic [31:0]        rd_data;
  logic               frame_start = 1'b0;
  logic               pix_valid = 1'b0;
  logic [DIM_W-1:0]   pix_x = '0;
  logic [DIM_W-1:0]   pix_y = '0;
  logic               rd_addr_valid;
  logic [31:0]        rd_addr;
  logic [PITCH_W-1:0] pitch_o;
  logic [SIZE_W-1:0]  size_o;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  fbv_scan_addr dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
    .wr_data(wr_data), .rd_sel(rd_sel), .rd_data(rd_data),
    .frame_start(frame_start), .pix_valid(pix_valid), .pix_x(pix_x),
    .pix_y(pix_y), .rd_addr_valid(rd_addr_valid), .rd_addr(rd_addr),
    .pitch_o(pitch_o), .size_o(size_o)
  );

  task automatic check(input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input int sel, input logic [31:0] val);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = 3'(sel); wr_data = val;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd_chk(input string req, input int sel, input logic [31:0] exp);
    rd_sel = 3'(sel);
    #1;
    check(req, rd_data, exp);
  endtask

  task automatic frame();
    @(negedge clk);
    frame_start = 1'b1;
    @(negedge clk);
    frame_start = 1'b0;
  endtask

  task automatic pix_chk(input string req, input int x, input int y,
                         input bit exp_v, input logic [31:0] exp_a);
    @(negedge clk);
    pix_valid = 1'b1; pix_x = DIM_W'(x); pix_y = DIM_W'(y);
    @(negedge clk);
    pix_valid = 1'b0;
    check(req, 32'(rd_addr_valid), 32'(exp_v));
    if (exp_v) check(req, rd_addr, exp_a);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic t_reset_state();
    do_reset();
    rd_chk("R1 disp_w", 0, 640);
    rd_chk("R1 disp_h", 1, 480);
    rd_chk("R1 buf_w", 2, 640);
    rd_chk("R1 buf_h", 3, 480);
    rd_chk("R1 org_x", 4, 0);
    rd_chk("R1 org_y", 5, 0);
    rd_chk("R1 depth", 6, 16);
    rd_chk("R1 base", 7, DBASE);
    check("R1 R8 pitch", 32'(pitch_o), 1280);
    check("R1 R8 size", 32'(size_o), 1280 * 480);
    check("R1 addr_valid idle", 32'(rd_addr_valid), 0);
    pix_chk("R1 R9 origin pixel", 0, 0, 1'b1, DBASE);
  endtask

  task automatic t_viewport();
    wr(2, 1024); wr(3, 768); wr(4, 100); wr(5, 50); wr(6, 32);
    wr(7, 32'h2000_0000);
    rd_chk("R6 buf_w", 2, 1024);
    rd_chk("R6 buf_h", 3, 768);
    rd_chk("R6 org_x", 4, 100);
    rd_chk("R6 org_y", 5, 50);
    rd_chk("R6 depth", 6, 32);
    rd_chk("R6 base", 7, 32'h2000_0000);
    // R7: still the old active set before the frame boundary
    check("R7 pitch held", 32'(pitch_o), 1280);
    pix_chk("R7 addr held", 1, 0, 1'b1, DBASE + 2);
    frame();
    check("R7 R8 pitch", 32'(pitch_o), 1024 * 4);
    check("R7 R8 size", 32'(size_o), 1024 * 4 * 768);
    pix_chk("R9 corner 0,0", 0, 0, 1'b1,
            32'h2000_0000 + 50 * 4096 + 100 * 4);
    pix_chk("R9 corner 639,479", 639, 479, 1'b1,
            32'h2000_0000 + 529 * 4096 + 739 * 4);
    pix_chk("R9 x outside", 640, 0, 1'b0, 0);
    pix_chk("R9 y outside", 0, 480, 1'b0, 0);
  endtask

  task automatic t_clamping();
    wr(4, 5000);
    rd_chk("R4 org_x clamp", 4, 1024 - 640);
    wr(5, 1000);
    rd_chk("R4 org_y clamp", 5, 768 - 480);
    wr(2, 100);
    rd_chk("R3 buf_w raised", 2, 640);
    rd_chk("R6 R4 org_x reclamped", 4, 0);
    wr(0, 3000);
    rd_chk("R2 disp_w max", 0, 2048);
    rd_chk("R3 R6 buf_w follows disp", 2, 2048);
    wr(0, 0);
    rd_chk("R2 disp_w zero", 0, 1);
    rd_chk("R3 buf_w kept", 2, 2048);
    wr(3, 5000);
    rd_chk("R3 buf_h max", 3, 2048);
    rd_chk("R4 org_y kept", 5, 288);
    wr(6, 7);
    rd_chk("R5 depth illegal", 6, 16);
    wr(6, 24);
    rd_chk("R5 depth 24", 6, 24);
    frame();
    check("R8 pitch 24bpp", 32'(pitch_o), 2048 * 3);
    check("R8 size 24bpp", 32'(size_o), 2048 * 3 * 2048);
    pix_chk("R9 R10 narrow 0,0", 0, 0, 1'b1, 32'h2000_0000 + 288 * 6144);
    pix_chk("R9 narrow x=1", 1, 0, 1'b0, 0);
    pix_chk("R9 narrow last row", 0, 479, 1'b1, 32'h2000_0000 + 767 * 6144);
  endtask

  task automatic t_reset_restore();
    do_reset();
    rd_chk("R1 restore disp_w", 0, 640);
    rd_chk("R1 restore depth", 6, 16);
    rd_chk("R1 restore base", 7, DBASE);
    check("R1 restore pitch", 32'(pitch_o), 1280);
    pix_chk("R1 R9 restore addr", 3, 2, 1'b1, DBASE + 2 * 1280 + 6);
  endtask

  initial begin
    t_reset_state();
    t_viewport();
    t_clamping();
    t_reset_restore();
    if (!finished) begin
      finished = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      total++;
      bad++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule